// File: doc/BRIEF.md
# Sticky Masked Interrupt Controller

This block collects a set of single-bit event conditions into one interrupt line. Each condition first passes through a parameterised synchronizer. A rising edge of the synchronized level sets a sticky status bit. A status bit clears only when software reads the status register and the condition has gone low by then. If the condition is still high at the read, the bit survives the read.

A per-bit mask register decides which events may raise the interrupt. A masked event is still recorded in the status register but never pulls the line. An unmasked event pulls the active-low, open-drain style interrupt line low. It stays low until the status register has been read. A read releases the line even when some conditions are still high, so software is not interrupted again by a level it has already seen. The register port is a plain single-cycle read/write strobe interface with combinational read data.

Top module: `sirq_ctrl`

## Requirements
- R1: A rising edge of condition bit i sets status bit i. With SYNC_STAGES = 2 the bit is visible after the third rising clock edge following the input change. A level that stays high sets the bit only once.
- R2: A set status bit stays set through any number of cycles without a status read. Mask reads and mask writes do not clear it.
- R3: A status read (address 0, reg_rd = 1) clears every status bit whose synchronized condition is low. Bits whose condition is still high stay set.
- R4: reg_rdata shows the status value as it was before the clear of the same read. Address 0 returns status, address 1 returns the mask, and any other address returns zero.
- R5: A write to address 0 has no effect on the status bits. A write to address 1 loads the mask, where bit value 1 means masked, and the new mask reads back.
- R6: An unmasked rising edge drives irq_n low in the same cycle its status bit becomes visible.
- R7: A masked rising edge sets its status bit but leaves irq_n high. Unmasking that bit later does not raise the interrupt.
- R8: Once low, irq_n stays low until a status read. The read releases irq_n (high) even if the condition is still present.
- R9: A rising edge that coincides with a status read is not lost. If unmasked, irq_n stays low after that read.
- R10: rst_n low asynchronously clears status and pending state, sets the mask to all ones, and releases irq_n at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_in | input | N_EVT | Raw event condition levels |
| reg_addr | input | ADDR_W | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | N_EVT | Write data |
| reg_rd | input | 1 | Read strobe; a status read clears bits |
| reg_rdata | output | N_EVT | Combinational read data |
| irq_n | output | 1 | Interrupt, low = asserted (drive-low request of an open-drain line) |

## Verification
The assertions assume that reg_rd and reg_wr are single-cycle strobes sampled on the clock edge. They also assume that a mask write is not combined with a status read when interrupt release is judged. The bench never raises both strobes in one cycle. It holds every condition level for at least three clocks, so each edge passes the synchronizer cleanly before the next change. The coincident edge-and-read case is placed deliberately, in the exact cycle the synchronized edge appears.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int unsigned SIRQ_ADDR_STATUS = 0;
   localparam int unsigned SIRQ_ADDR_MASK   = 1;
   localparam int unsigned SIRQ_MAX_SYNC    = 4;
endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import sirq_pkg::*;
   if (STAGES > SIRQ_MAX_SYNC) begin : g_bad
      $error("sirq_sync: STAGES too large");
   end
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/sirq_edge.sv
module sirq_edge #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end
   for (genvar i = 0; i < int'(W); i++) begin : g_bit
      assign rise[i] = level[i] & ~prev_q[i];
   end
endmodule

// File: rtl/sirq_status_bank.sv
module sirq_status_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rise,
   input  logic [W-1:0] level,
   input  logic [W-1:0] mask_q,
   input  logic         rd_clr,
   output logic [W-1:0] status_q,
   output logic [W-1:0] pend_q
);
   for (genvar i = 0; i < int'(W); i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status_q[i] <= 1'b0;
            pend_q[i]   <= 1'b0;
         end else begin
            if (rise[i])                  status_q[i] <= 1'b1;
            else if (rd_clr && !level[i]) status_q[i] <= 1'b0;
            if (rise[i] && !mask_q[i])    pend_q[i]   <= 1'b1;
            else if (rd_clr)              pend_q[i]   <= 1'b0;
         end
      end
   end

   a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> ((status_q & $past(status_q)) == $past(status_q)));
   a_r3_keep_live: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> ((status_q & $past(status_q & level)) == $past(status_q & level)));
   a_r3_clear_gone: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> ((status_q & $past(status_q & ~level & ~rise)) == '0));
   a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && ((rise & ~mask_q) != '0))
      |=> ((pend_q & $past(rise & ~mask_q)) == $past(rise & ~mask_q)));
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl #(
   parameter int unsigned N_EVT       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  cond_in,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [N_EVT-1:0]  reg_wdata,
   input  logic              reg_rd,
   output logic [N_EVT-1:0]  reg_rdata,
   output logic              irq_n
);
   import sirq_pkg::*;
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(SIRQ_ADDR_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(SIRQ_ADDR_MASK);

   if (N_EVT < 1 || N_EVT > 64) begin : g_bad_n
      $error("sirq_ctrl: N_EVT out of range");
   end
   if (ADDR_W < 1) begin : g_bad_a
      $error("sirq_ctrl: ADDR_W must be at least 1");
   end

   logic [N_EVT-1:0] level, rise, status_q, pend_q, mask_q;
   logic             sel_status, sel_mask, rd_clr;

   assign sel_status = (reg_addr == A_STATUS);
   assign sel_mask   = (reg_addr == A_MASK);
   assign rd_clr     = reg_rd & sel_status;

   sirq_sync #(.W(N_EVT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cond_in), .q(level));

   sirq_edge #(.W(N_EVT)) u_edge (
      .clk(clk), .rst_n(rst_n), .level(level), .rise(rise));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mask_q <= '1;
      else if (reg_wr && sel_mask) mask_q <= reg_wdata;
   end

   sirq_status_bank #(.W(N_EVT)) u_bank (
      .clk(clk), .rst_n(rst_n), .rise(rise), .level(level),
      .mask_q(mask_q), .rd_clr(rd_clr), .status_q(status_q), .pend_q(pend_q));

   always_comb begin
      reg_rdata = '0;
      if (sel_status)    reg_rdata = status_q;
      else if (sel_mask) reg_rdata = mask_q;
   end

   assign irq_n = ~|(pend_q & ~mask_q);

   a_r6_unmasked_fires: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise & ~mask_q) != '0 && !(reg_wr && sel_mask)) |=> !irq_n);
   a_r7_quiet_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_n && (rise & ~mask_q) == '0) |=> irq_n);
   a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !reg_wr && rise == '0) |=> irq_n);
   a_r8_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !rd_clr && !reg_wr) |=> !irq_n);
endmodule

// File: tb/sirq_ctrl_tb.sv
module sirq_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] cond_in = '0;
   logic [1:0]   reg_addr = '0;
   logic         reg_wr = 1'b0;
   logic [N-1:0] reg_wdata = '0;
   logic         reg_rd = 1'b0;
   logic [N-1:0] reg_rdata;
   logic         irq_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sirq_ctrl #(.N_EVT(N), .ADDR_W(2), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata), .irq_n(irq_n));

   // fields: cond[28:21] rd[20] wr[19] addr[18:17] wdata[16:9] exp_rd[8:1] exp_irq_n[0]
   localparam logic [28:0] VEC [16] = '{
      {8'h00, 1'b0, 1'b1, 2'd1, 8'hF0, 8'h00, 1'b1},  // R5 unmask low nibble
      {8'h01, 1'b1, 1'b0, 2'd1, 8'h00, 8'hF0, 1'b0},  // R6 fire, R5 mask read
      {8'h01, 1'b1, 1'b0, 2'd0, 8'h00, 8'h01, 1'b1},  // R8 release with level high
      {8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 8'h01, 1'b1},  // R3 kept bit, now clears
      {8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 1'b1},  // R3 cleared
      {8'h10, 1'b1, 1'b0, 2'd0, 8'h00, 8'h10, 1'b1},  // R7 masked records only
      {8'h00, 1'b0, 1'b1, 2'd1, 8'h00, 8'h00, 1'b1},  // R7 unmask later, no fire
      {8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 8'h10, 1'b1},  // R2 survived mask write
      {8'h06, 1'b0, 1'b1, 2'd0, 8'hFF, 8'h00, 1'b0},  // R5 status write ignored
      {8'h06, 1'b1, 1'b0, 2'd0, 8'h00, 8'h06, 1'b1},  // R5 value intact, R4
      {8'h00, 1'b1, 1'b0, 2'd3, 8'h00, 8'h00, 1'b1},  // R4 unused address
      {8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 8'h06, 1'b1},  // R4 pre-clear value
      {8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 1'b1},  // R3 all cleared
      {8'h80, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0},  // R1 R6 top bit
      {8'h80, 1'b1, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0},  // R2 mask read no clear
      {8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 8'h80, 1'b1}   // R1 single set, R8
   };

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_read(input logic [1:0] a, input string req, input logic [N-1:0] exp);
      reg_addr = a; reg_rd = 1'b1;
      #1 check(req, reg_rdata, exp);
      clocks(1);
      reg_rd = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      clocks(2);
      check("R10 irq_n in reset", {7'd0, irq_n}, 8'h01);
      rst_n = 1'b1;
      clocks(1);
      do_read(2'd1, "R10 mask default", 8'hFF);
      do_read(2'd0, "R10 status default", 8'h00);

      for (int v = 0; v < 16; v++) begin
         logic [28:0] e;
         e = VEC[v];
         cond_in = e[28:21];
         clocks(3);
         reg_addr = e[18:17]; reg_wdata = e[16:9];
         reg_rd = e[20]; reg_wr = e[19];
         #1;
         if (e[20]) check($sformatf("R4 vector %0d read", v), reg_rdata, e[8:1]);
         clocks(1);
         reg_rd = 1'b0; reg_wr = 1'b0;
         check($sformatf("R6 vector %0d irq_n", v), {7'd0, irq_n}, {7'd0, e[0]});
      end

      // R9: edge arriving in the cycle of a status read (mask is all clear here)
      cond_in = 8'h08; clocks(3);
      cond_in = 8'h00; clocks(3);
      check("R6 bit3 irq", {7'd0, irq_n}, 8'h00);
      do_read(2'd0, "R9 setup read", 8'h08);
      check("R8 released", {7'd0, irq_n}, 8'h01);
      cond_in = 8'h08; clocks(2);
      do_read(2'd0, "R9 read returns pre-edge status", 8'h00);
      check("R9 irq kept after coincident read", {7'd0, irq_n}, 8'h00);
      cond_in = 8'h00; clocks(3);
      do_read(2'd0, "R9 bit recorded", 8'h08);
      check("R9 irq released", {7'd0, irq_n}, 8'h01);

      // R10: asynchronous reset while interrupt asserted
      cond_in = 8'h02; clocks(3);
      check("R6 before reset", {7'd0, irq_n}, 8'h00);
      #2 rst_n = 1'b0;
      #1 check("R10 immediate release", {7'd0, irq_n}, 8'h01);
      cond_in = 8'h00;
      clocks(1);
      rst_n = 1'b1;
      clocks(3);
      do_read(2'd0, "R10 status cleared", 8'h00);
      do_read(2'd1, "R10 mask restored", 8'hFF);
      // R7 after reset all masked: event records but no interrupt
      cond_in = 8'h01; clocks(3);
      check("R7 masked after reset", {7'd0, irq_n}, 8'h01);
      do_read(2'd0, "R7 status recorded", 8'h01);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule